// File: doc/BRIEF.md
# DRAM Multipurpose Register Mode Controller

This block models how a DDR3-style memory device handles its multipurpose register mode. It watches a decoded command bus and keeps one bit of state: whether reads are being served from a fixed pattern instead of the memory array. A mode-register-set command aimed at mode register 3 turns the mode on or off. The block only accepts the turn-on request when every bank is precharged. While the mode is on, each READ or READ-with-auto-precharge plays out a burst of predefined data. Any other command is refused with a one-cycle error pulse and changes nothing.

The block has a simple command interface. Each clock carries one command code, a two-bit mode-register selector, an address field and a per-bank idle vector. The outputs are the mode state, which doubles as the read-source select (1 means reads come from the pattern source), a data-valid strobe, the data word for all DQ lanes, and the error pulse. A parameter chooses how the data is driven. In prime-lane output the pattern bit appears only on lane 0 of each byte. In all-lanes output every lane carries the same bit.

Top module: `mpr_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows mpr_on=0, dq_valid=0, dq=0 and cmd_err=0.
- R2: Command codes are NOP=0, ACT=1, RD=2, RDAP=3, WR=4, MRS=5, PDE=6, SRE=7. An MRS with mr_sel=3 and addr[2]=1, issued while the mode is off and every banks_idle bit is 1, sets mpr_on in the next cycle with no error. The same command also stores addr[1:0] as the pattern selector.
- R3: The same entry command issued while any banks_idle bit is 0 pulses cmd_err in the next cycle, and mpr_on stays 0.
- R4: An MRS with mr_sel=3 and addr[2]=0, issued while the mode is on, clears mpr_on in the next cycle.
- R5: While the mode is on, a RD or RDAP starts a burst of 8 beats. dq_valid is high for the 8 cycles that begin one cycle after the command.
- R6: With selector 0, the burst bits are 0,1,0,1,0,1,0,1 in beat order. Selectors 1, 2 and 3 return all-zero beats with dq_valid still high.
- R7: In prime-lane output (PRIME_ONLY=1, the default), bit 0 of each 8-bit byte carries the beat bit and every other lane is 0. In all-lanes output, every lane carries the beat bit.
- R8: While the mode is on, any command other than NOP, RD, RDAP or the exit MRS pulses cmd_err for one cycle and is otherwise ignored. This covers ACT, WR, PDE, SRE, MRS to other registers, and MRS to register 3 with addr[2]=1. mpr_on, the pattern selector and any running burst are unaffected.
- R9: While the mode is off, RD, RDAP, WR, ACT and MRS commands that are not the entry command produce no data and no error, and mpr_on stays 0.
- R10: A RD issued on the last beat continues seamlessly into a new 8-beat burst. A RD issued mid-burst restarts the burst at beat 0.
- R11: The exit command aborts a running burst, so dq_valid is 0 from the next cycle on.
- R12: Reset is legal during the mode. It clears the mode and any burst, so a later RD gives no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Decoded command code |
| mr_sel | input | 2 | Mode register selector for MRS |
| addr | input | AW | Address field; bits [2:0] carry the register 3 fields |
| banks_idle | input | NBANK | One bit per bank, 1 when precharged |
| mpr_on | output | 1 | Mode state; 1 selects the pattern source for reads |
| dq_valid | output | 1 | Burst beat valid |
| dq | output | BYTES*LANES | Data word across all lanes |
| cmd_err | output | 1 | One-cycle pulse for a refused command |

## Verification
A wrong mode bit shows at the ports on the very next cycle. mpr_on is itself an output, and a read then either produces a burst or produces nothing. A stale pattern selector or a beat counter that is off by one shows within the 8-cycle burst window, as a beat holding the wrong bit or a valid strobe that stops at the wrong length. Errors injected mid-burst, and reads that restart a burst, are compared on every cycle against a bench model. A burst that a refused command wrongly disturbs is therefore caught on the following beat.

// File: rtl/mpr_mode_ctrl.sv
module mpr_mode_ctrl #(
  parameter int BYTES      = 2,
  parameter int LANES      = 8,
  parameter int NBANK      = 8,
  parameter int AW         = 14,
  parameter int BURST      = 8,
  parameter int PRIME_ONLY = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd,
  input  logic [1:0]             mr_sel,
  input  logic [AW-1:0]          addr,
  input  logic [NBANK-1:0]       banks_idle,
  output logic                   mpr_on,
  output logic                   dq_valid,
  output logic [BYTES*LANES-1:0] dq,
  output logic                   cmd_err
);
  localparam int DQW = BYTES * LANES;
  localparam int BW  = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd2, C_RDAP = 3'd3, C_MRS = 3'd5;
  localparam logic [BW-1:0] LAST = BW'(BURST - 1);

  logic [1:0]    pat_sel;
  logic [BW-1:0] beat;

  wire is_mr3   = (cmd == C_MRS) && (mr_sel == 2'd3);
  wire want_on  = is_mr3 && addr[2];
  wire want_off = is_mr3 && !addr[2];
  wire is_rd    = (cmd == C_RD) || (cmd == C_RDAP);
  wire all_idle = &banks_idle;
  wire refuse   = mpr_on ? (cmd != C_NOP) && !is_rd && !want_off
                         : want_on && !all_idle;
  wire beat_bit = dq_valid && (pat_sel == 2'd0) && beat[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mpr_on   <= 1'b0;
      dq_valid <= 1'b0;
      cmd_err  <= 1'b0;
      pat_sel  <= 2'd0;
      beat     <= '0;
    end else begin
      cmd_err <= refuse;
      if (!mpr_on && want_on && all_idle) begin
        mpr_on  <= 1'b1;
        pat_sel <= addr[1:0];
      end else if (mpr_on && want_off) begin
        mpr_on   <= 1'b0;
        dq_valid <= 1'b0;
      end else if (mpr_on && is_rd) begin
        dq_valid <= 1'b1;
        beat     <= '0;
      end else if (dq_valid) begin
        if (beat == LAST) dq_valid <= 1'b0;
        else beat <= beat + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    if (PRIME_ONLY != 0) begin : g_prime
      assign dq[g*LANES +: LANES] = {{(LANES-1){1'b0}}, beat_bit};
    end else begin : g_all
      assign dq[g*LANES +: LANES] = {LANES{beat_bit}};
    end
  end

  logic unused_ok;
  assign unused_ok = ^{addr[AW-1:3], 1'b0};
endmodule

module mpr_mode_ctrl_chk #(
  parameter int BYTES      = 2,
  parameter int LANES      = 8,
  parameter int NBANK      = 8,
  parameter int AW         = 14,
  parameter int PRIME_ONLY = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             cmd,
  input logic [1:0]             mr_sel,
  input logic [AW-1:0]          addr,
  input logic [NBANK-1:0]       banks_idle,
  input logic                   mpr_on,
  input logic                   dq_valid,
  input logic [BYTES*LANES-1:0] dq,
  input logic                   cmd_err
);
  wire mr3 = (cmd == 3'd5) && (mr_sel == 2'd3);
  wire rd  = (cmd == 3'd2) || (cmd == 3'd3);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !mpr_on && !dq_valid && !cmd_err);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mpr_on && mr3 && addr[2] && &banks_idle) |=> mpr_on && !cmd_err);
  p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mpr_on && mr3 && addr[2] && !(&banks_idle)) |=> cmd_err && !mpr_on);
  p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mpr_on && mr3 && !addr[2]) |=> !mpr_on && !dq_valid);
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mpr_on && rd) |=> dq_valid && dq == '0);
  p_src_r5: assert property (@(posedge clk) disable iff (!rst_n) dq_valid |-> mpr_on);
  p_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (PRIME_ONLY != 0) |-> $countones(dq) <= BYTES);
  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mpr_on && cmd != 3'd0 && !rd && !(mr3 && !addr[2])) |=> cmd_err && mpr_on);
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mpr_on && !(mr3 && addr[2])) |=> !cmd_err && !mpr_on && !dq_valid);
  p_quiet_r8: assert property (@(posedge clk) !dq_valid |-> dq == '0);
endmodule

bind mpr_mode_ctrl mpr_mode_ctrl_chk #(
  .BYTES(BYTES), .LANES(LANES), .NBANK(NBANK), .AW(AW), .PRIME_ONLY(PRIME_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .mr_sel(mr_sel), .addr(addr),
  .banks_idle(banks_idle), .mpr_on(mpr_on), .dq_valid(dq_valid), .dq(dq),
  .cmd_err(cmd_err)
);

// File: tb/sim_mpr_mode_ctrl.sv
module sim_mpr_mode_ctrl;
  localparam int BYTES = 2, LANES = 8, NBANK = 8, AW = 14;
  localparam int DQW = BYTES * LANES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] mr_sel = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [NBANK-1:0] banks_idle = '1;
  logic mpr_on, dq_valid, cmd_err;
  logic [DQW-1:0] dq;

  always #5 clk = ~clk;

  mpr_mode_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmd(cmd), .mr_sel(mr_sel), .addr(addr),
    .banks_idle(banks_idle), .mpr_on(mpr_on), .dq_valid(dq_valid), .dq(dq), .cmd_err(cmd_err));

  int checks = 0, errors = 0;
  string phase = "R1 reset";
  bit done = 0;

  // reference model state
  bit m_on = 0, m_err = 0;
  int m_sel = 0, m_left = 0, m_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_err = 0; m_sel = 0; m_left = 0; m_idx = 0;
    end else begin
      bit entry, exitc, readc;
      entry = (cmd == 5) && (mr_sel == 3) && addr[2];
      exitc = (cmd == 5) && (mr_sel == 3) && !addr[2];
      readc = (cmd == 2) || (cmd == 3);
      m_err = 0;
      if (m_left > 0) begin m_left--; m_idx++; end
      if (!m_on) begin
        if (entry && banks_idle == '1) begin m_on = 1; m_sel = addr[1:0]; end
        else if (entry) m_err = 1;
      end else if (exitc) begin
        m_on = 0; m_left = 0;
      end else if (readc) begin
        m_left = 8; m_idx = 0;
      end else if (cmd != 0) begin
        m_err = 1;
      end
    end
  end

  function automatic logic [DQW-1:0] exp_dq();
    logic [DQW-1:0] v = '0;
    bit b = (m_left > 0) && (m_sel == 0) && (m_idx % 2 == 1);
    for (int i = 0; i < DQW; i++) v[i] = (i % LANES == 0) ? b : 1'b0;
    return v;
  endfunction

  always @(negedge clk) if (!done) begin
    checks++;
    if (mpr_on !== m_on || dq_valid !== (m_left > 0) || cmd_err !== m_err || dq !== exp_dq()) begin
      errors++;
      $display("FAIL %s: got on=%0b v=%0b err=%0b dq=%h expected on=%0b v=%0b err=%0b dq=%h",
               phase, mpr_on, dq_valid, cmd_err, dq, m_on, m_left > 0, m_err, exp_dq());
    end
  end

  task automatic issue(input logic [2:0] c, input logic [1:0] s = 0,
                       input logic [AW-1:0] a = 0, input logic [NBANK-1:0] idle = '1);
    @(posedge clk); #1;
    cmd = c; mr_sel = s; addr = a; banks_idle = idle;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) issue(3'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_n(3);
    @(posedge clk); #1 rst_n = 1;
    phase = "R9 off-mode commands";
    issue(2); issue(4); issue(3); issue(1);
    issue(5, 3, 14'b011); issue(5, 1, 14'b100); issue(0);
    phase = "R3 entry with open bank";
    issue(5, 3, 14'b100, 8'hFE); issue(0); issue(0);
    phase = "R2 entry";
    issue(5, 3, 14'b100); idle_n(2);
    phase = "R5 R6 R7 read burst";
    issue(2); idle_n(9);
    issue(3); idle_n(10);
    phase = "R10 back-to-back reads";
    issue(2); idle_n(7); issue(2); idle_n(3); issue(2); idle_n(10);
    phase = "R8 refused commands mid-burst";
    issue(2); issue(1); issue(4); issue(6); issue(7);
    issue(5, 0, 14'b100); issue(5, 3, 14'b101); idle_n(6);
    phase = "R4 R11 exit aborts burst";
    issue(2); idle_n(2); issue(5, 3, 14'b000); idle_n(3);
    phase = "R6 reserved selector";
    issue(5, 3, 14'b110); issue(2); idle_n(10);
    phase = "R12 reset in mode";
    issue(2); idle_n(2);
    @(posedge clk); #1 rst_n = 0; cmd = 0;
    idle_n(2);
    @(posedge clk); #1 rst_n = 1;
    issue(2); idle_n(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule